// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a link to a 14-bit successive-approximation converter that has a three-wire serial port. A start request makes it drive the active-low select line low. It then produces a chosen number of serial clock pulses, derived from the system clock by an even divide ratio. The converter runs its conversion on the falling edges of that clock. While it converts, it shifts out the result of the conversion from the previous frame. The reader samples the data line on falling edges and assembles the word MSB first. It checks that the bits around the word are zero. At the end of the frame it releases select and holds it high for a minimum number of system clocks, which gives the converter time to acquire the next sample.

Each result is presented for one cycle with a valid strobe and three flags. The result-invalid flag is raised for the first result after reset and for any result that follows a frame with too few clocks. The short-frame flag marks a frame that itself had too few clocks. The framing-error flag marks a frame whose leading or trailing bits were not zero. The clock count is sampled from an input at each start, so software above this block can issue deliberately short frames.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, and until the first start, select is high, the serial clock is low, busy is low, the strobe is low and the data output is zero.
- R2: A start pulse seen while the block is idle makes select go low at the next clock edge. A start that arrives while busy is high has no effect: no extra frame follows, and the clock count of the running frame is unchanged.
- R3: A frame produces exactly as many serial clock falling edges as the frame_clks value sampled at start, with a count of 0 treated as 1. The serial clock idles low, its period is DIV_RATIO system clocks, and select stays low for DIV_RATIO times the count in system clocks.
- R4: Data bit 13 (MSB) down to bit 0 are sampled on falling edges 2 through 15. A frame with n < 15 edges yields the first n-1 received bits, right-aligned in dout.
- R5: The bit sampled on falling edge 1 is the leading bit. If it is 1, frame_err is set for that frame.
- R6: Any 1 sampled on falling edge 16 or later sets frame_err for that frame.
- R7: dout_valid is a single-cycle pulse. It rises while select is already high after the last falling edge, and dout changes only when dout_valid is high.
- R8: The first result after reset has result_invalid set.
- R9: A frame with fewer than 18 falling edges sets short_frame on its own result and result_invalid on the next result. A result that follows a full frame, other than the first, has result_invalid clear.
- R10: Between two frames, select stays high for at least GAP_CYCLES system clocks.
- R11: busy is high from the edge that accepts a start until the minimum high time ends, and select is high whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request one frame; taken only when idle |
| frame_clks | input | CNT_W | Serial clock count for the frame, sampled at start |
| busy | output | 1 | Frame or minimum high time in progress |
| cs_n | output | 1 | Active-low select to the converter |
| sclk | output | 1 | Serial clock, idles low |
| sdo | input | 1 | Serial data from the converter |
| dout | output | DATA_W | Assembled result |
| dout_valid | output | 1 | One-cycle strobe for dout and flags |
| result_invalid | output | 1 | First result after reset, or follows a short frame |
| short_frame | output | 1 | This frame had fewer than MIN_CLKS falling edges |
| frame_err | output | 1 | A leading or trailing bit was 1 |

## Verification
The assertions assume that start and frame_clks are synchronous to clk. They also assume that sdo changes only after serial clock rising edges or at the fall of select, so it is steady at every falling edge where the reader samples it. The bench meets both conditions. It drives start and frame_clks on falling system clock edges. Its converter model updates sdo only at select falling and at serial clock rising, using the bit schedule from R4 to R6. Framing faults are injected only by changing the value the model sends on the leading bit or on one trailing bit.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLK  = 2'd1,
    ST_GAP  = 2'd2
  } afr_state_e;
endpackage

// File: rtl/afr_sclk_gen.sv
module afr_sclk_gen #(
  parameter int DIV_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_evt
);
  localparam int HALF = DIV_RATIO / 2;

  logic sclk_q, sclk_d;
  logic tick;

  generate
    if (HALF <= 1) begin : g_fast
      assign tick = run;
    end else begin : g_cnt
      localparam int PH_W = $clog2(HALF);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);
      logic [PH_W-1:0] ph_q, ph_d;

      always_comb begin
        ph_d = ph_q;
        if (!run)                ph_d = '0;
        else if (ph_q == PH_LAST) ph_d = '0;
        else                     ph_d = ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign tick = run && (ph_q == PH_LAST);
    end
  endgenerate

  always_comb begin
    sclk_d = sclk_q;
    if (!run)      sclk_d = 1'b0;
    else if (tick) sclk_d = ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  assign sclk     = sclk_q;
  assign fall_evt = tick && sclk_q;
endmodule

// File: rtl/afr_bit_capture.sv
module afr_bit_capture #(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall_evt,
  input  logic [CNT_W-1:0]  fall_idx,
  input  logic              sdo,
  output logic [DATA_W-1:0] word,
  output logic              err
);
  localparam logic [CNT_W-1:0] LEAD_IDX = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W + 1);

  logic [DATA_W-1:0] word_q, word_d;
  logic              err_q, err_d;

  always_comb begin
    word_d = word_q;
    err_d  = err_q;
    if (clr) begin
      word_d = '0;
      err_d  = 1'b0;
    end else if (fall_evt) begin
      if (fall_idx == LEAD_IDX)       err_d  = err_q | sdo;
      else if (fall_idx <= LAST_IDX)  word_d = {word_q[DATA_W-2:0], sdo};
      else                            err_d  = err_q | sdo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      err_q  <= err_d;
    end
  end

  assign word = word_q;
  assign err  = err_q;
endmodule

// File: rtl/afr_frame_fsm.sv
module afr_frame_fsm
  import afr_pkg::*;
#(
  parameter int MIN_CLKS   = 18,
  parameter int CNT_W      = 5,
  parameter int GAP_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frame_clks,
  input  logic             fall_evt,
  output logic             run,
  output logic             busy,
  output logic             cs_n,
  output logic             accept,
  output logic [CNT_W-1:0] fall_idx,
  output logic             last_fall,
  output logic             short_now
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);
  localparam logic [CNT_W-1:0] MIN_N    = CNT_W'(MIN_CLKS);

  afr_state_e       state_q, state_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  assign accept    = (state_q == ST_IDLE) && start;
  assign last_fall = (state_q == ST_CLK) && fall_evt && (cnt_q == n_q - 1'b1);

  always_comb begin
    state_d = state_q;
    n_d     = n_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CLK;
          n_d     = (frame_clks == '0) ? CNT_W'(1) : frame_clks;
          cnt_d   = '0;
        end
      end
      ST_CLK: begin
        if (fall_evt) begin
          cnt_d = cnt_q + 1'b1;
          if (last_fall) begin
            state_d = ST_GAP;
            gap_d   = '0;
          end
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_LAST) state_d = ST_IDLE;
        else                   gap_d   = gap_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      n_q     <= n_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
    end
  end

  assign run       = (state_q == ST_CLK);
  assign cs_n      = (state_q != ST_CLK);
  assign busy      = (state_q != ST_IDLE);
  assign fall_idx  = cnt_q + 1'b1;
  assign short_now = (n_q < MIN_N);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_W     = 14,
  parameter int MIN_CLKS   = 18,
  parameter int MAX_CLKS   = 31,
  parameter int DIV_RATIO  = 4,
  parameter int GAP_CYCLES = 6,
  localparam int CNT_W     = $clog2(MAX_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  frame_clks,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  input  logic              sdo,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              result_invalid,
  output logic              short_frame,
  output logic              frame_err
);
  logic rst_meta_q, rst_sync_q, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_s = rst_sync_q;

  logic             run, accept, fall_evt, last_fall, short_now;
  logic [CNT_W-1:0] fall_idx;
  logic [DATA_W-1:0] cap_word;
  logic             cap_err;

  afr_frame_fsm #(
    .MIN_CLKS  (MIN_CLKS),
    .CNT_W     (CNT_W),
    .GAP_CYCLES(GAP_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .frame_clks(frame_clks),
    .fall_evt  (fall_evt),
    .run       (run),
    .busy      (busy),
    .cs_n      (cs_n),
    .accept    (accept),
    .fall_idx  (fall_idx),
    .last_fall (last_fall),
    .short_now (short_now)
  );

  afr_sclk_gen #(
    .DIV_RATIO(DIV_RATIO)
  ) u_sclk (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (run),
    .sclk    (sclk),
    .fall_evt(fall_evt)
  );

  afr_bit_capture #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (accept),
    .fall_evt(fall_evt),
    .fall_idx(fall_idx),
    .sdo     (sdo),
    .word    (cap_word),
    .err     (cap_err)
  );

  // Result stage: loads one cycle after the last falling edge.
  logic              done_q;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              valid_q, valid_d;
  logic              inv_q, inv_d;
  logic              short_q, short_d;
  logic              err_q, err_d;
  logic              first_q, first_d;
  logic              prev_short_q, prev_short_d;

  always_comb begin
    dout_d       = dout_q;
    valid_d      = 1'b0;
    inv_d        = inv_q;
    short_d      = short_q;
    err_d        = err_q;
    first_d      = first_q;
    prev_short_d = prev_short_q;
    if (done_q) begin
      dout_d       = cap_word;
      valid_d      = 1'b1;
      inv_d        = first_q | prev_short_q;
      short_d      = short_now;
      err_d        = cap_err;
      first_d      = 1'b0;
      prev_short_d = short_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q       <= 1'b0;
      dout_q       <= '0;
      valid_q      <= 1'b0;
      inv_q        <= 1'b0;
      short_q      <= 1'b0;
      err_q        <= 1'b0;
      first_q      <= 1'b1;
      prev_short_q <= 1'b0;
    end else begin
      done_q       <= last_fall;
      dout_q       <= dout_d;
      valid_q      <= valid_d;
      inv_q        <= inv_d;
      short_q      <= short_d;
      err_q        <= err_d;
      first_q      <= first_d;
      prev_short_q <= prev_short_d;
    end
  end

  assign dout           = dout_q;
  assign dout_valid     = valid_q;
  assign result_invalid = inv_q;
  assign short_frame    = short_q;
  assign frame_err      = err_q;
endmodule

// File: rtl/adc_frame_reader_sva.sv
module adc_frame_reader_sva #(
  parameter int DATA_W     = 14,
  parameter int GAP_CYCLES = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              cs_n,
  input logic              sclk,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input logic              result_invalid
);
  localparam int HW = $clog2(GAP_CYCLES + 2) + 1;
  localparam logic [HW-1:0] HMAX = '1;

  logic [HW-1:0] hi_cnt;
  logic          seen_frame, seen_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
      seen_valid <= 1'b0;
    end else begin
      if (!cs_n)              hi_cnt <= '0;
      else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + 1'b1;
      if (!cs_n)     seen_frame <= 1'b1;
      if (dout_valid) seen_valid <= 1'b1;
    end
  end

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r11_idle_select_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  a_r2_select_falls_on_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && !$past(busy)));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);

  a_r7_strobe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (cs_n && busy));

  a_r7_dout_changes_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> dout_valid);

  a_r8_first_result_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !seen_valid) |-> result_invalid);

  a_r10_min_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_frame) |-> (int'(hi_cnt) >= GAP_CYCLES));
endmodule

bind adc_frame_reader adc_frame_reader_sva #(
  .DATA_W    (DATA_W),
  .GAP_CYCLES(GAP_CYCLES)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .cs_n          (cs_n),
  .sclk          (sclk),
  .dout          (dout),
  .dout_valid    (dout_valid),
  .result_invalid(result_invalid)
);

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int DATA_W = 14;
  localparam int MINC   = 18;
  localparam int DIV    = 4;
  localparam int GAP    = 6;
  localparam int CNT_W  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, start, busy, cs_n, sclk, sdo;
  logic [CNT_W-1:0]  frame_clks;
  logic [DATA_W-1:0] dout;
  logic              dout_valid, result_invalid, short_frame, frame_err;

  adc_frame_reader #(
    .DATA_W(DATA_W), .MIN_CLKS(MINC), .MAX_CLKS(31),
    .DIV_RATIO(DIV), .GAP_CYCLES(GAP)
  ) u_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_clks(frame_clks),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .dout(dout),
    .dout_valid(dout_valid), .result_invalid(result_invalid),
    .short_frame(short_frame), .frame_err(frame_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Converter model
  logic [DATA_W-1:0] tx_word = '0;
  bit  lead_one = 1'b0, trail_one = 1'b0;
  int  rise_cnt = 0;
  int  falls = 0;
  int  hi_run = 0, last_gap = 0;
  bit  first_m = 1'b1, prev_short_m = 1'b0;
  int  frames_m = 0;

  initial sdo = 1'b0;

  always @(negedge cs_n) begin
    rise_cnt = 0;
    sdo <= lead_one;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      rise_cnt++;
      if (rise_cnt >= 2 && rise_cnt <= 15) sdo <= tx_word[15 - rise_cnt];
      else if (rise_cnt >= 16)             sdo <= (trail_one && rise_cnt == 17);
    end
  end

  always @(negedge sclk) falls++;

  always @(negedge clk) begin
    if (cs_n) hi_run++;
    else begin
      if (hi_run > 0) last_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic run_frame(input int n, input logic [DATA_W-1:0] next_conv,
                           input bit lead, input bit trail, input bit poke);
    int neff, lo;
    logic [DATA_W-1:0] exp_d;
    bit exp_inv, exp_err;
    neff    = (n == 0) ? 1 : n;
    exp_inv = first_m || prev_short_m;
    exp_d   = (neff >= 15) ? tx_word : (tx_word >> (15 - neff));
    exp_err = lead || (trail && neff >= 17);
    lead_one  = lead;
    trail_one = trail;
    while (busy) @(negedge clk);
    falls = 0;
    @(negedge clk);
    frame_clks = CNT_W'(n);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R2", "select low after idle start", cs_n, 0);
    lo = 1;
    forever begin
      @(negedge clk);
      start = poke && (lo == 8);
      if (poke && lo == 8) frame_clks = CNT_W'(3);
      if (dout_valid) break;
      if (!cs_n) lo++;
    end
    start = 1'b0;
    chk(lo == DIV * neff, "R3", "select low cycles", lo, DIV * neff);
    chk(falls == neff, "R3", "falling edges", falls, neff);
    chk(cs_n && !sclk, "R7", "select high, clock low at strobe", {cs_n, sclk}, 2);
    chk(dout == exp_d, "R4", "data word", dout, exp_d);
    chk(result_invalid == exp_inv, (first_m ? "R8" : "R9"), "invalid flag",
        result_invalid, exp_inv);
    chk(short_frame == (neff < MINC), "R9", "short flag", short_frame, neff < MINC);
    chk(frame_err == exp_err, (lead ? "R5" : "R6"), "framing error", frame_err, exp_err);
    if (frames_m > 0)
      chk(last_gap >= GAP, "R10", "select high gap", last_gap, GAP);
    @(negedge clk);
    chk(!dout_valid, "R7", "strobe one cycle", dout_valid, 0);
    chk(busy, "R11", "busy through gap", busy, 1);
    tx_word      = (neff >= MINC) ? next_conv : 14'h1555;
    first_m      = 1'b0;
    prev_short_m = (neff < MINC);
    frames_m++;
    if (poke) begin
      repeat (GAP + 4) @(negedge clk);
      chk(!busy && cs_n, "R2", "start while busy ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    frame_clks = CNT_W'(MINC);
    repeat (5) @(negedge clk);
    chk(cs_n && !sclk && !busy && !dout_valid && dout == '0, "R1",
        "reset state", {cs_n, sclk, busy, dout_valid}, 8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && !sclk && !busy && !dout_valid && dout == '0, "R1",
        "post-reset idle", {cs_n, sclk, busy, dout_valid}, 8);

    run_frame(18, 14'h2AAA, 0, 0, 0);
    run_frame(18, 14'h3FFF, 0, 0, 0);
    run_frame(18, 14'h0000, 0, 0, 0);
    for (int n = 18; n <= 31; n++)
      run_frame(n, DATA_W'((n * 32'h0357 + 32'h00A5) & 32'h3FFF), 0, 0, 0);
    run_frame(16, 14'h1234, 0, 0, 0);
    run_frame(18, 14'h0F0F, 0, 0, 0);
    run_frame(18, 14'h2001, 0, 0, 0);
    run_frame(5,  14'h0111, 0, 0, 0);
    run_frame(0,  14'h0222, 0, 0, 0);
    run_frame(15, 14'h0333, 0, 0, 0);
    run_frame(20, 14'h3C3C, 0, 0, 0);
    run_frame(20, 14'h1B6D, 0, 0, 0);
    run_frame(18, 14'h2468, 1, 0, 0);
    run_frame(18, 14'h1357, 0, 1, 0);
    run_frame(16, 14'h0ACE, 0, 1, 0);
    run_frame(19, 14'h3001, 0, 0, 0);
    run_frame(24, 14'h07E0, 0, 0, 1);
    run_frame(18, 14'h0000, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule